// File: doc/BRIEF.md
# Transmit Buffer Byte Counter

This block tracks how many bytes of one transmit buffer remain to be read by a DMA engine. A 16-bit length word from the transmit descriptor is loaded as the two's complement of the byte count. Each fetched byte advances the counter by one. The buffer is finished when the counter reaches zero.

An all-zero length word is caught at load time and treated as an empty buffer. No DMA request is raised, and the descriptor is handed back to the host at once through a one-cycle ownership-release pulse. A word with the upper four bits set and the lower twelve clear (0xF000) is not empty: it is a normal 4096-byte buffer. Descriptor fetch, memory access and the write-back of the owner bit are handled by the surrounding logic.

Top module: `tx_byte_counter`

## Requirements
- R1: After reset, dma_req_o, last_o, done_o and own_rel_o are all 0.
- R2: A load of the all-zero word makes done_o 1 and own_rel_o 1 in the cycle after the load edge, and dma_req_o stays 0.
- R3: A load of any nonzero word W makes dma_req_o 1 and done_o 0 in the cycle after the load edge. The buffer then holds 65536 minus W bytes.
- R4: Each fetch_i sampled while dma_req_o is 1 and load_i is 0 uses up exactly one byte. Cycles without fetch_i use up none.
- R5: last_o is 1 exactly while dma_req_o is 1 and one byte remains (the counter is all ones).
- R6: The fetch that uses the last byte clears dma_req_o and sets done_o in the next cycle, and own_rel_o is 1 in that same cycle.
- R7: fetch_i is ignored while no buffer is active (before any load and after done). Outputs do not change and done_o stays 1.
- R8: A load of 0xF000 is a 4096-byte buffer: dma_req_o stays 1 for exactly 4096 fetches.
- R9: load_i takes priority over fetch_i in the same cycle and restarts the count from the new word, even in the middle of a buffer.
- R10: Each release event drives own_rel_o for exactly one cycle. It stays 1 in the following cycle only if that cycle is caused by another release event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_word_i | input | 16 | Descriptor length word, two's complement of byte count |
| load_i | input | 1 | Load strobe for desc_word_i |
| fetch_i | input | 1 | One byte fetched from the buffer |
| dma_req_o | output | 1 | Buffer active, DMA may fetch |
| last_o | output | 1 | Next fetch is the final byte |
| done_o | output | 1 | Buffer finished or empty |
| own_rel_o | output | 1 | One-cycle pulse: return descriptor to host |

## Verification
Every state change happens on the clock edge that samples load_i or fetch_i. dma_req_o, done_o and own_rel_o therefore change in the cycle right after the strobe, and last_o follows the registered count in that same cycle. The bench drives inputs and samples outputs on the falling edge. After each rising edge it advances a behavioural model that counts remaining bytes as an integer, so every output is compared one cycle after its stimulus, with no extra latency allowed.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tbc_state_e;
endpackage

// File: rtl/tbc_zero_det.sv
module tbc_zero_det #(
  parameter int W     = 16,
  parameter int SEG_W = 4
) (
  input  logic [W-1:0] word_i,
  output logic         zero_o
);
  localparam int NSEG = W / SEG_W;
  logic [NSEG-1:0] seg_zero;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_zero[s] = ~|word_i[s*SEG_W +: SEG_W];
  end

  assign zero_o = &seg_zero;
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int W     = 16,
  parameter int SEG_W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ones_o
);
  localparam int NSEG = W / SEG_W;

  logic [W-1:0]    cnt_q;
  logic [W-1:0]    cnt_inc;
  logic [NSEG:0]   carry;
  logic [NSEG-1:0] seg_ones;

  assign carry[0] = 1'b1;

  // segmented incrementer: carry skips across all-ones segments
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg;
    assign seg         = cnt_q[s*SEG_W +: SEG_W];
    assign seg_ones[s] = &seg;
    assign carry[s+1]  = carry[s] & seg_ones[s];
    assign cnt_inc[s*SEG_W +: SEG_W] = carry[s] ? seg + SEG_W'(1) : seg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_inc;
  end

  assign cnt_o  = cnt_q;
  assign ones_o = carry[NSEG];

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (cnt_q == $past(cnt_q) + W'(1))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic word_zero_i,
  input  logic fetch_i,
  input  logic cnt_ones_i,
  output logic inc_o,
  output logic dma_req_o,
  output logic last_o,
  output logic done_o,
  output logic own_rel_o
);
  tbc_state_e state_q, state_d;
  logic       rel_q, rel_d;
  logic       run;

  assign run   = (state_q == ST_RUN);
  assign inc_o = run && fetch_i && !load_i;

  always_comb begin
    state_d = state_q;
    rel_d   = 1'b0;
    if (load_i) begin
      if (word_zero_i) begin
        state_d = ST_DONE;
        rel_d   = 1'b1;
      end else begin
        state_d = ST_RUN;
      end
    end else if (inc_o && cnt_ones_i) begin
      state_d = ST_DONE;
      rel_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
    end
  end

  assign dma_req_o = run;
  assign last_o    = run && cnt_ones_i;
  assign done_o    = (state_q == ST_DONE);
  assign own_rel_o = rel_q;

  AST_ZERO_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && word_zero_i) |=> (done_o && !dma_req_o && own_rel_o)); // R2
  AST_LOAD_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !word_zero_i) |=> (dma_req_o && !done_o)); // R3
  AST_LAST_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> dma_req_o); // R5
  AST_FINAL_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && fetch_i && !load_i) |=> (done_o && !dma_req_o && own_rel_o)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (done_o && !own_rel_o)); // R7
  AST_REL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_rel_o |=> (!own_rel_o || $past(load_i))); // R10
  AST_MUTEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_req_o, done_o})); // R3
endmodule

// File: rtl/tx_byte_counter.sv
module tx_byte_counter #(
  parameter int CNT_W = 16,
  parameter int SEG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] desc_word_i,
  input  logic             load_i,
  input  logic             fetch_i,
  output logic             dma_req_o,
  output logic             last_o,
  output logic             done_o,
  output logic             own_rel_o
);
  logic             word_zero;
  logic             inc;
  logic             cnt_ones;
  logic [CNT_W-1:0] cnt;

  tbc_zero_det #(.W(CNT_W), .SEG_W(SEG_W)) u_zero (
    .word_i (desc_word_i),
    .zero_o (word_zero)
  );

  tbc_counter #(.W(CNT_W), .SEG_W(SEG_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (desc_word_i),
    .inc_i      (inc),
    .cnt_o      (cnt),
    .ones_o     (cnt_ones)
  );

  tbc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .word_zero_i (word_zero),
    .fetch_i     (fetch_i),
    .cnt_ones_i  (cnt_ones),
    .inc_o       (inc),
    .dma_req_o   (dma_req_o),
    .last_o      (last_o),
    .done_o      (done_o),
    .own_rel_o   (own_rel_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (!dma_req_o && !done_o && !own_rel_o) || $past(load_i)); // R1
  AST_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (cnt != '0)); // R8
endmodule

// File: tb/sim_tx_byte_counter.sv
module sim_tx_byte_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word = '0;
  logic        load = 1'b0;
  logic        fetch = 1'b0;
  logic        dma_req, last, done, own_rel;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";

  // reference model
  int m_rem = 0;
  bit m_act = 0, m_dn = 0, m_rel = 0;

  always #4 clk = ~clk;

  tx_byte_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .desc_word_i(word),
    .load_i(load), .fetch_i(fetch),
    .dma_req_o(dma_req), .last_o(last), .done_o(done), .own_rel_o(own_rel)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem <= 0; m_act <= 0; m_dn <= 0; m_rel <= 0;
    end else begin
      m_rel <= 0;
      if (load) begin
        if (word == 16'h0) begin
          m_act <= 0; m_dn <= 1; m_rel <= 1;
        end else begin
          m_rem <= 65536 - int'(word); m_act <= 1; m_dn <= 0;
        end
      end else if (fetch && m_act) begin
        if (m_rem == 1) begin
          m_act <= 0; m_dn <= 1; m_rel <= 1;
        end
        m_rem <= m_rem - 1;
      end
    end
  end

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {dma_req,last,done,own_rel} actual=%b expected=%b at %0t",
               r, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n)
      chk(tag, {dma_req, last, done, own_rel},
          {m_act, m_act && (m_rem == 1), m_dn, m_rel});
  end

  task automatic cyc(input bit l, input logic [15:0] w, input bit f);
    load = l; word = w; fetch = f;
    @(negedge clk);
    load = 0; fetch = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", {dma_req, last, done, own_rel}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {dma_req, last, done, own_rel}, 4'b0000);

    tag = "R7";                         // fetches before any load
    for (int i = 0; i < 3; i++) cyc(0, 16'h0, 1);
    chk("R7", {dma_req, last, done, own_rel}, 4'b0000);

    tag = "R2";                         // zero-length buffer
    cyc(1, 16'h0000, 0);
    chk("R2", {dma_req, done, own_rel}, {1'b0, 3'b011} );
    cyc(0, 16'h0, 0);
    chk("R10", {own_rel}, 1'b0);

    tag = "R10";                        // back-to-back zero loads
    cyc(1, 16'h0000, 0);
    cyc(1, 16'h0000, 0);
    chk("R10", {own_rel, done}, 2'b11);
    cyc(0, 16'h0, 0);
    chk("R10", {own_rel}, 1'b0);

    tag = "R3";                         // 3-byte buffer with gaps
    cyc(1, 16'hFFFD, 0);
    chk("R3", {dma_req, done}, 2'b10);
    tag = "R4";
    cyc(0, 16'h0, 1);
    cyc(0, 16'h0, 0);
    cyc(0, 16'h0, 1);
    tag = "R5";
    chk("R5", {last}, 1'b1);
    cyc(0, 16'h0, 0);
    chk("R5", {last}, 1'b1);
    tag = "R6";
    cyc(0, 16'h0, 1);
    chk("R6", {dma_req, done, own_rel}, 3'b011);

    tag = "R7";                         // fetches after done
    for (int i = 0; i < 4; i++) cyc(0, 16'h0, 1);
    chk("R7", {dma_req, done, own_rel}, 3'b010);

    tag = "R5";                         // single-byte buffer
    cyc(1, 16'hFFFF, 0);
    chk("R5", {dma_req, last}, 2'b11);
    cyc(0, 16'h0, 1);
    chk("R6", {dma_req, done, own_rel}, 3'b011);

    tag = "R8";                         // 0xF000 = 4096 bytes
    cyc(1, 16'hF000, 0);
    chk("R8", {dma_req, done, own_rel}, 3'b100);
    for (int i = 0; i < 4095; i++) cyc(0, 16'h0, 1);
    chk("R8", {dma_req, last}, 2'b11);
    cyc(0, 16'h0, 1);
    chk("R8", {dma_req, done, own_rel}, 3'b011);

    tag = "R9";                         // reload mid-buffer with fetch
    cyc(1, 16'hFFF0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 16'h0, 1);
    cyc(1, 16'hFFFE, 1);
    chk("R9", {dma_req, last}, 2'b10);
    cyc(0, 16'h0, 1);
    chk("R9", {last}, 1'b1);
    cyc(1, 16'h0000, 1);                // zero load wins over final fetch
    chk("R9", {dma_req, done, own_rel}, 3'b011);

    tag = "R4";                         // mixed widths
    cyc(1, 16'h8000, 0);
    for (int i = 0; i < 300; i++) cyc(0, 16'h0, (i % 3) != 1);
    cyc(1, 16'hFFF8, 0);
    for (int i = 0; i < 12; i++) cyc(0, 16'h0, 1);
    chk("R6", {dma_req, done}, 2'b01);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule